// File: doc/BRIEF.md
# Receiver Trim Calibration Controller

This controller sets the four digital trim codes of a strobed sense-amplifier optical receiver. Two codes cancel the input-referred offset of the two sense-amplifier lanes (lane A and lane B). One code sets the shunt current that places the front-end swing symmetrically about the fixed decision threshold. One code selects the sampling phase of the delay-locked clock. Calibration starts by itself when reset is released. It runs again each time the link logic pulses `recal`.

The trims are done one at a time, in a fixed order: offset A, then offset B, then shunt level, then sampling phase. During both offset stages `null_in` asks the front end to null its optical input. Each code has a force enable for test. While a force enable is set, the output shows the forced value and the controller skips that stage.

Samples arrive as a valid-only stream: `smp_valid` marks a cycle that carries sense-amplifier decisions on `smp_bit` and an error flag on `smp_err`. The controller takes every valid beat, so there is no ready signal and no back-pressure. The source may leave gaps of any length, and the controller ignores cycles where `smp_valid` is low.

Top module: `rx_trim_cal`

## Requirements
- R1: On reset all four trim outputs equal the code midpoint 2^(CODE_W-1) (32 for 6 bits), `null_in` is 1 and `cal_done` is 0. Calibration starts without any trigger.
- R2: The stages run in this order: offset A, offset B (both with `null_in`=1), shunt level, sampling phase. After the last stage `cal_done` is 1 and stays 1 until `recal`. Only one search engine is active at a time.
- R3: Each offset code is found by a successive-approximation search, MSB first. Lane A uses `smp_bit[0]` and lane B uses `smp_bit[1]`. For each bit the trial code has that bit set. If more than half of OFS_N (default 64) valid samples are 1, the bit is cleared. The result is the largest code whose lane majority is not 1.
- R4: The shunt-level code starts at the midpoint and is judged on windows of LVL_WIN (default 1024) valid `smp_bit[0]` samples. If the ones count is above LVL_WIN/2+LVL_TOL, the code is decremented. If it is below LVL_WIN/2-LVL_TOL, the code is incremented. Otherwise the stage ends. The stage also ends when the needed step would pass code 0 or the maximum code.
- R5: The phase code sweeps from 0 up to the maximum, holding each code for PH_WIN (default 8) valid samples. A code passes when `smp_err` was 0 on all of them. The final code is floor((first passing + last passing)/2). If no code passes, the final code is the midpoint.
- R6: A cycle with `smp_valid`=0 has no effect on any count or decision.
- R7: A `recal` pulse in any stage restarts from offset A. In the next cycle `null_in` is 1 and `cal_done` is 0.
- R8: The force enables map as `frc_en[0]` offset A, `[1]` offset B, `[2]` shunt level and `[3]` phase. A set enable makes that trim output equal its force value in the same cycle, and that stage is skipped. The other codes are still calibrated.
- R9: The shunt-level and phase codes do not change during the offset stages. The offset codes do not change after their stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| recal | input | 1 | Periodic recalibration pulse |
| smp_valid | input | 1 | Sample beat valid |
| smp_bit | input | 2 | Sense-amplifier decisions, lane A in bit 0, lane B in bit 1 |
| smp_err | input | 1 | Sample error flag used by the phase sweep |
| frc_en | input | 4 | Per-code force enables |
| frc_ofs_a | input | CODE_W | Forced offset A code |
| frc_ofs_b | input | CODE_W | Forced offset B code |
| frc_lvl | input | CODE_W | Forced shunt-level code |
| frc_ph | input | CODE_W | Forced phase code |
| trim_ofs_a | output | CODE_W | Offset A trim code |
| trim_ofs_b | output | CODE_W | Offset B trim code |
| trim_lvl | output | CODE_W | Shunt-current trim code |
| trim_ph | output | CODE_W | Sampling phase trim code |
| null_in | output | 1 | Request to null the optical input (offset stages) |
| cal_done | output | 1 | Calibration complete |

## Verification
The bench models the front end. It drives a noisy comparator per lane, a ones density that moves with the shunt-level code, and an error flag outside a chosen passing window of phase codes. Against this model it checks the following:
- Offset targets at 0 and 63. A search that sets or clears bits the wrong way lands one code off, or at the opposite end.
- A shunt target at either code limit. This exposes an off-by-one step or a stop at the wrong bound.
- Passing phase windows of width one at the first and last code, and a sweep with no passing code. A wrong centre rounding or a missing fallback shows up as a wrong phase code.
- A `recal` pulse in the middle of the level stage, and forced codes. A controller that does not restart, or that still drives a forced code, ends with stale or overwritten codes.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic [2:0] {
    ST_OFS_A = 3'd0,
    ST_OFS_B = 3'd1,
    ST_LVL   = 3'd2,
    ST_PH    = 3'd3,
    ST_DONE  = 3'd4
  } cal_st_t;

  localparam int NUM_TRIMS = 4;
endpackage

// File: rtl/rtc_sar.sv
module rtc_sar #(
  parameter int W = 6,
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         abort,
  input  logic         start,
  input  logic         s_valid,
  input  logic         s_bit,
  output logic [W-1:0] code,
  output logic         busy,
  output logic         fin
);
  localparam int CW = $clog2(N);
  localparam int IW = $clog2(W);
  localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

  logic [CW-1:0] cnt;
  logic [CW:0]   ones, ones_tot;
  logic [IW-1:0] idx;
  logic          last, high;
  logic [W-1:0]  nxt;

  assign last     = (cnt == CW'(N-1));
  assign ones_tot = ones + {{CW{1'b0}}, s_bit};
  assign high     = ones_tot > (CW+1)'(N/2);

  // resolve the current bit and arm the next lower one
  always_comb begin
    nxt = code;
    if (high) nxt[idx] = 1'b0;
    if (idx != '0) nxt[idx - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= MID;
      busy <= 1'b0;
      fin  <= 1'b0;
      cnt  <= '0;
      ones <= '0;
      idx  <= IW'(W-1);
    end else begin
      fin <= 1'b0;
      if (abort) begin
        busy <= 1'b0;
      end else if (start) begin
        code <= MID;
        idx  <= IW'(W-1);
        cnt  <= '0;
        ones <= '0;
        busy <= 1'b1;
      end else if (busy && s_valid) begin
        if (last) begin
          cnt  <= '0;
          ones <= '0;
          code <= nxt;
          if (idx == '0) begin
            busy <= 1'b0;
            fin  <= 1'b1;
          end else begin
            idx <= idx - 1'b1;
          end
        end else begin
          cnt  <= cnt + 1'b1;
          ones <= ones_tot;
        end
      end
    end
  end
endmodule

// File: rtl/rtc_level.sv
module rtc_level #(
  parameter int W   = 6,
  parameter int WIN = 1024,
  parameter int TOL = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         abort,
  input  logic         start,
  input  logic         s_valid,
  input  logic         s_bit,
  output logic [W-1:0] code,
  output logic         busy,
  output logic         fin
);
  localparam int CW = $clog2(WIN);
  localparam int HI_LIM = WIN/2 + TOL;
  localparam int LO_LIM = WIN/2 - TOL;
  localparam logic [W-1:0] MID  = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] CMAX = {W{1'b1}};

  logic [CW-1:0] cnt;
  logic [CW:0]   ones, ones_tot;
  logic          last, too_hi, too_lo;

  assign last     = (cnt == CW'(WIN-1));
  assign ones_tot = ones + {{CW{1'b0}}, s_bit};
  assign too_hi   = int'(ones_tot) > HI_LIM;
  assign too_lo   = int'(ones_tot) < LO_LIM;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= MID;
      busy <= 1'b0;
      fin  <= 1'b0;
      cnt  <= '0;
      ones <= '0;
    end else begin
      fin <= 1'b0;
      if (abort) begin
        busy <= 1'b0;
      end else if (start) begin
        code <= MID;
        cnt  <= '0;
        ones <= '0;
        busy <= 1'b1;
      end else if (busy && s_valid) begin
        if (last) begin
          cnt  <= '0;
          ones <= '0;
          if (too_hi && code != '0) begin
            code <= code - 1'b1;
          end else if (too_lo && code != CMAX) begin
            code <= code + 1'b1;
          end else begin
            busy <= 1'b0;
            fin  <= 1'b1;
          end
        end else begin
          cnt  <= cnt + 1'b1;
          ones <= ones_tot;
        end
      end
    end
  end
endmodule

// File: rtl/rtc_phase.sv
module rtc_phase #(
  parameter int W   = 6,
  parameter int WIN = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         abort,
  input  logic         start,
  input  logic         s_valid,
  input  logic         s_err,
  output logic [W-1:0] code,
  output logic         busy,
  output logic         fin
);
  localparam int CW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam logic [W-1:0] MID  = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] CMAX = {W{1'b1}};

  logic [CW-1:0] cnt;
  logic [W-1:0]  lo, hi, lo_n, hi_n;
  logic          found, found_n, err_seen, last, pass;
  logic [W:0]    mid_sum;

  assign last    = (cnt == CW'(WIN-1));
  assign pass    = !(err_seen || s_err);
  assign lo_n    = (pass && !found) ? code : lo;
  assign hi_n    = pass ? code : hi;
  assign found_n = found || pass;
  assign mid_sum = {1'b0, lo_n} + {1'b0, hi_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code     <= MID;
      busy     <= 1'b0;
      fin      <= 1'b0;
      cnt      <= '0;
      lo       <= '0;
      hi       <= '0;
      found    <= 1'b0;
      err_seen <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (abort) begin
        busy <= 1'b0;
      end else if (start) begin
        code     <= '0;
        cnt      <= '0;
        found    <= 1'b0;
        err_seen <= 1'b0;
        busy     <= 1'b1;
      end else if (busy && s_valid) begin
        if (last) begin
          cnt      <= '0;
          err_seen <= 1'b0;
          lo       <= lo_n;
          hi       <= hi_n;
          found    <= found_n;
          if (code == CMAX) begin
            busy <= 1'b0;
            fin  <= 1'b1;
            code <= found_n ? mid_sum[W:1] : MID;
          end else begin
            code <= code + 1'b1;
          end
        end else begin
          cnt      <= cnt + 1'b1;
          err_seen <= err_seen || s_err;
        end
      end
    end
  end
endmodule

// File: rtl/rx_trim_cal.sv
module rx_trim_cal
  import rtc_pkg::*;
#(
  parameter int CODE_W  = 6,
  parameter int OFS_N   = 64,
  parameter int LVL_WIN = 1024,
  parameter int LVL_TOL = 16,
  parameter int PH_WIN  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              recal,
  input  logic              smp_valid,
  input  logic [1:0]        smp_bit,
  input  logic              smp_err,
  input  logic [3:0]        frc_en,
  input  logic [CODE_W-1:0] frc_ofs_a,
  input  logic [CODE_W-1:0] frc_ofs_b,
  input  logic [CODE_W-1:0] frc_lvl,
  input  logic [CODE_W-1:0] frc_ph,
  output logic [CODE_W-1:0] trim_ofs_a,
  output logic [CODE_W-1:0] trim_ofs_b,
  output logic [CODE_W-1:0] trim_lvl,
  output logic [CODE_W-1:0] trim_ph,
  output logic              null_in,
  output logic              cal_done
);
  cal_st_t                   st;
  logic                      launched;
  logic [1:0]                st_idx;
  logic [NUM_TRIMS-1:0]      eng_start, eng_abort, eng_busy, eng_fin;
  logic [CODE_W-1:0]         raw [NUM_TRIMS];

  assign st_idx = st[1:0];

  // one start pulse per stage, suppressed when the stage is forced
  always_comb begin
    eng_start = '0;
    if (st != ST_DONE && !launched && !frc_en[st_idx] && !recal)
      eng_start[st_idx] = 1'b1;
  end
  assign eng_abort = {NUM_TRIMS{recal}} | frc_en;

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_ofs
      rtc_sar #(.W(CODE_W), .N(OFS_N)) u_sar (
        .clk(clk), .rst_n(rst_n), .abort(eng_abort[g]), .start(eng_start[g]),
        .s_valid(smp_valid), .s_bit(smp_bit[g]),
        .code(raw[g]), .busy(eng_busy[g]), .fin(eng_fin[g])
      );
    end
  endgenerate

  rtc_level #(.W(CODE_W), .WIN(LVL_WIN), .TOL(LVL_TOL)) u_lvl (
    .clk(clk), .rst_n(rst_n), .abort(eng_abort[2]), .start(eng_start[2]),
    .s_valid(smp_valid), .s_bit(smp_bit[0]),
    .code(raw[2]), .busy(eng_busy[2]), .fin(eng_fin[2])
  );

  rtc_phase #(.W(CODE_W), .WIN(PH_WIN)) u_ph (
    .clk(clk), .rst_n(rst_n), .abort(eng_abort[3]), .start(eng_start[3]),
    .s_valid(smp_valid), .s_err(smp_err),
    .code(raw[3]), .busy(eng_busy[3]), .fin(eng_fin[3])
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_OFS_A;
      launched <= 1'b0;
    end else if (recal) begin
      st       <= ST_OFS_A;
      launched <= 1'b0;
    end else if (st != ST_DONE) begin
      if (frc_en[st_idx] || (launched && eng_fin[st_idx])) begin
        st       <= cal_st_t'(st + 3'd1);
        launched <= 1'b0;
      end else if (!launched) begin
        launched <= 1'b1;
      end
    end
  end

  assign trim_ofs_a = frc_en[0] ? frc_ofs_a : raw[0];
  assign trim_ofs_b = frc_en[1] ? frc_ofs_b : raw[1];
  assign trim_lvl   = frc_en[2] ? frc_lvl   : raw[2];
  assign trim_ph    = frc_en[3] ? frc_ph    : raw[3];
  assign null_in    = (st == ST_OFS_A) || (st == ST_OFS_B);
  assign cal_done   = (st == ST_DONE);
endmodule

// File: rtl/rx_trim_cal_chk.sv
module rx_trim_cal_chk #(
  parameter int W = 6
) (
  input logic         clk,
  input logic         rst_n,
  input logic         recal,
  input logic         null_in,
  input logic         cal_done,
  input logic [3:0]   eng_busy,
  input logic [W-1:0] raw_ofs_a,
  input logic [W-1:0] raw_ofs_b,
  input logic [W-1:0] raw_lvl,
  input logic [W-1:0] raw_ph
);
  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    recal |=> (null_in && !cal_done));

  a_r2_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_done && !recal) |=> cal_done);

  a_r2_single_engine: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eng_busy));

  a_r9_lvl_ph_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (null_in && !recal) |=> ($stable(raw_lvl) && $stable(raw_ph)));

  a_r9_ofs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!null_in && !recal) |=> ($stable(raw_ofs_a) && $stable(raw_ofs_b)));
endmodule

bind rx_trim_cal rx_trim_cal_chk #(.W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .recal(recal), .null_in(null_in),
  .cal_done(cal_done), .eng_busy(eng_busy),
  .raw_ofs_a(raw[0]), .raw_ofs_b(raw[1]), .raw_lvl(raw[2]), .raw_ph(raw[3])
);

// File: tb/rx_trim_cal_tb.sv
module rx_trim_cal_tb;
  localparam int W    = 6;
  localparam int LWIN = 256;
  localparam int LTOL = 4;
  localparam int STEP = LWIN * 40 / 1024;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         recal = 1'b0;
  logic         smp_valid = 1'b0;
  logic [1:0]   smp_bit = 2'b00;
  logic         smp_err = 1'b0;
  logic [3:0]   frc_en = 4'b0;
  logic [W-1:0] frc_ofs_a = '0, frc_ofs_b = '0, frc_lvl = '0, frc_ph = '0;
  logic [W-1:0] trim_ofs_a, trim_ofs_b, trim_lvl, trim_ph;
  logic         null_in, cal_done;

  int checks = 0;
  int fails  = 0;
  int ta, tb, tl, plo, phi;
  int acc = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  rx_trim_cal #(.CODE_W(W), .LVL_WIN(LWIN), .LVL_TOL(LTOL)) u_dut (
    .clk(clk), .rst_n(rst_n), .recal(recal), .smp_valid(smp_valid),
    .smp_bit(smp_bit), .smp_err(smp_err), .frc_en(frc_en),
    .frc_ofs_a(frc_ofs_a), .frc_ofs_b(frc_ofs_b), .frc_lvl(frc_lvl), .frc_ph(frc_ph),
    .trim_ofs_a(trim_ofs_a), .trim_ofs_b(trim_ofs_b), .trim_lvl(trim_lvl),
    .trim_ph(trim_ph), .null_in(null_in), .cal_done(cal_done)
  );

  function automatic int exp_ph(int lo, int hi);
    return (lo <= hi) ? (lo + hi) / 2 : 32;
  endfunction

  function automatic int lvl_density(int code, int tgt);
    int d;
    d = LWIN / 2 + STEP * (code - tgt);
    if (d < 0) d = 0;
    if (d > LWIN) d = LWIN;
    return d;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // front-end model, driven away from the active edge
  initial begin
    void'($urandom(32'd1234));
    forever begin
      @(negedge clk);
      smp_valid = ($urandom % 10) < 8;
      smp_err   = !((int'(trim_ph) >= plo) && (int'(trim_ph) <= phi));
      if (null_in) begin
        smp_bit[0] = (int'(trim_ofs_a) > ta) ^ (($urandom % 8) == 0);
        smp_bit[1] = (int'(trim_ofs_b) > tb) ^ (($urandom % 8) == 0);
      end else begin
        smp_bit[1] = 1'($urandom % 2);
        if (smp_valid) begin
          acc += lvl_density(int'(trim_lvl), tl);
          if (acc >= LWIN) begin
            smp_bit[0] = 1'b1;
            acc -= LWIN;
          end else begin
            smp_bit[0] = 1'b0;
          end
        end
      end
    end
  end

  task automatic wait_done(string tag);
    int n = 0;
    while (!cal_done && n < 40000) begin
      @(negedge clk);
      n++;
    end
    if (!cal_done) check({tag, " timeout"}, 0, 1);
  endtask

  task automatic pulse_recal();
    @(negedge clk);
    recal = 1'b1;
    @(negedge clk);
    recal = 1'b0;
    // R7: restart seen one cycle after the pulse
    check("R7 null_in after recal", null_in, 1);
    check("R7 cal_done after recal", cal_done, 0);
  endtask

  task automatic check_all(string tag);
    check({tag, " R2 cal_done"}, cal_done, 1);
    check({tag, " R2 null_in low"}, null_in, 0);
    check({tag, " R3 R6 offset A"}, trim_ofs_a, ta);
    check({tag, " R3 R6 offset B"}, trim_ofs_b, tb);
    check({tag, " R4 level"}, trim_lvl, tl);
    check({tag, " R5 phase"}, trim_ph, exp_ph(plo, phi));
  endtask

  task automatic set_targets(int a, int b, int l, int lo, int hi);
    ta = a; tb = b; tl = l; plo = lo; phi = hi; acc = 0;
  endtask

  task automatic rand_targets();
    int lo = $urandom % 60;
    set_targets($urandom % 64, $urandom % 64, 4 + $urandom % 56, lo, lo + $urandom % 4);
  endtask

  initial begin
    set_targets(20, 45, 28, 10, 17);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: start-up state
    check("R1 offset A reset", trim_ofs_a, 32);
    check("R1 offset B reset", trim_ofs_b, 32);
    check("R1 level reset", trim_lvl, 32);
    check("R1 phase reset", trim_ph, 32);
    check("R1 null_in", null_in, 1);
    check("R1 cal_done", cal_done, 0);
    wait_done("startup R1");
    check_all("startup");

    for (int i = 0; i < 2; i++) begin
      rand_targets();
      pulse_recal();
      wait_done("random");
      check_all("random");
    end

    // boundary targets and one-code phase windows
    set_targets(0, 63, 63, 0, 0);
    pulse_recal(); wait_done("edge1"); check_all("edge1");
    set_targets(63, 0, 0, 63, 63);
    pulse_recal(); wait_done("edge2"); check_all("edge2");
    set_targets(31, 32, 33, 1, 0);  // no passing phase code
    pulse_recal(); wait_done("nopass"); check_all("nopass");

    // R7: restart in the middle of the level stage
    set_targets(7, 50, 12, 30, 40);
    pulse_recal();
    repeat (2500) @(negedge clk);
    check("R7 mid-run not done", cal_done, 0);
    pulse_recal();
    wait_done("R7 restart");
    check_all("R7 restart");

    // R8: forcing offset A and level
    @(negedge clk);
    frc_en = 4'b0101; frc_ofs_a = 6'd17; frc_lvl = 6'd9;
    #1;
    check("R8 forced offset A now", trim_ofs_a, 17);
    check("R8 forced level now", trim_lvl, 9);
    set_targets(40, 22, 50, 5, 9);
    pulse_recal();
    wait_done("R8");
    check("R8 forced offset A held", trim_ofs_a, 17);
    check("R8 forced level held", trim_lvl, 9);
    check("R8 offset B calibrated", trim_ofs_b, 22);
    check("R8 phase calibrated", trim_ph, exp_ph(5, 9));
    frc_en = 4'b0000;
    pulse_recal();
    wait_done("R8 release");
    check_all("R8 release");

    // R8: force phase after done, then release
    @(negedge clk);
    frc_en = 4'b1000; frc_ph = 6'd5;
    #1;
    check("R8 forced phase", trim_ph, 5);
    @(negedge clk);
    frc_en = 4'b0000;
    #1;
    check("R8 phase after release", trim_ph, exp_ph(5, 9));

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule